// File: doc/BRIEF.md
# Sink-Style Rule Update Controller

This controller applies rule changes to a two-dimensional classification array whose rows are split into stages of STRIDE header bits. Some stages of some rows have no vector table: they are fixed wildcard stages, and a rule that has a fixed 0 or 1 bit in such a stage cannot be held in that row. The controller keeps one valid bit per slot of every row. It knows the wildcard stage map as a parameter (bit `r*NSTG+g` set means stage g of row r has no table). From one command it issues the per-entry table writes and the valid-bit writes that the array needs.

A command carries an operation, a rule identifier and a ternary pattern (value plus care mask, care bit 1 = fixed bit). The identifier's upper RW bits name the home row and its lower SW bits the slot. An insert is placed in the home row if it fits. Otherwise it sinks row by row, keeping its slot column, until a row has that slot free and no wildcard stage under a fixed bit of the rule. A delete only clears a valid bit. A modify clears the old placement first and then inserts. When no row down to the bottom accepts the rule, the command ends with an overflow status so that outside logic can rebalance. A separate flag shows that the bottom row is full.

FSM states: IDLE (waiting, ready), DROP (clear the home valid bit), SEEK (test one candidate row per cycle), FILL (one table entry per cycle), ARM (set the valid bit), DONE (one-cycle completion pulse). Transitions: IDLE to DONE for the no-op code; IDLE to SEEK on insert; IDLE to DROP on delete or modify; DROP to DONE on delete, to SEEK on modify; SEEK to FILL on fit, to DONE with overflow at the bottom row, else SEEK on the next row; FILL to ARM on the last step; ARM to DONE; DONE to IDLE.

Top module: `sink_rule_updater`

## Requirements
- R1: After reset, every valid bit is clear, cmd_ready is 1, and done, bottom_full, tw_en and vb_en are 0.
- R2: A delete (cmd_op 2'b10) issues exactly one valid write with vb_val 0 at the home row and slot, with no table write, in any row including rows with wildcard stages; done then reports that row and slot with done_ovf 0.
- R3: An insert (cmd_op 2'b01) whose home slot is free and whose fixed bits avoid the home row's wildcard stages lands in the home row. For each standard stage g of the landing row, it writes all 2^STRIDE keys. The written bit is 1 exactly when the key equals the rule value on the fixed bits of rule bits [g*STRIDE +: STRIDE]. Wildcard stages receive no write.
- R4: Otherwise the rule sinks. Rows below are tested in order, and rows whose slot is taken or that have a wildcard stage under a fixed bit are skipped; the rule lands in the first row that fits, in the same slot, and done_row/done_slot report it (conflicts in the next two rows land it three rows down).
- R5: A modify (cmd_op 2'b11) first issues a valid write of 0 at the home row and slot, before any table write, and then places the new pattern as an insert searching from the home row.
- R6: When no row down to the bottom row fits, done comes with done_ovf 1, no table write and no valid set; a modify's old placement stays cleared.
- R7: A landing issues exactly one valid write with vb_val 1, at the landing row and slot, in the cycle after the last table write.
- R8: cmd_ready is 0 from the cycle after acceptance through the done cycle; a held command is not taken again. Busy cycles are: delete 2; insert = rows tested + (landing: standard stages * 2^STRIDE + wildcard stages + 2, overflow: 1); modify = insert + 1.
- R9: bottom_full is 1 exactly when every slot of the bottom row is valid, from the done cycle of the command that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command taken at this edge |
| cmd_op | input | 2 | 00 no-op, 01 insert, 10 delete, 11 modify |
| cmd_id | input | RW+SW | Rule identifier: {home row, slot} |
| cmd_value | input | NSTG*STRIDE | Rule value bits |
| cmd_care | input | NSTG*STRIDE | Care mask, 1 = fixed bit |
| tw_en | output | 1 | Table entry write strobe |
| tw_row | output | RW | Row of the table write |
| tw_slot | output | SW | Slot (vector bit) of the table write |
| tw_stage | output | GW | Stage of the table write |
| tw_key | output | STRIDE | Table key (entry address) |
| tw_bit | output | 1 | Bit value written |
| vb_en | output | 1 | Valid-bit write strobe |
| vb_row | output | RW | Row of the valid write |
| vb_slot | output | SW | Slot of the valid write |
| vb_val | output | 1 | New valid value |
| done | output | 1 | Command complete (one cycle) |
| done_ovf | output | 1 | No row could hold the rule |
| done_row | output | RW | Final row |
| done_slot | output | SW | Final slot |
| bottom_full | output | 1 | All bottom-row slots valid |

## Verification
Two functions of this block can land in one cycle. The first is a new command standing at the input in the cycle that done pulses. The bench holds cmd_valid high through every busy period and drops it only at the done cycle, so an early or repeated acceptance shows up in the busy-cycle count and in a second valid write. The second is bottom_full rising in the same cycle as the done pulse of the insert that takes the last bottom slot. The bench checks the flag against its own occupancy model at that done cycle, both when the flag rises and when a delete drops it.

// File: rtl/upd_pkg.sv
package upd_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_INS = 2'b01,
        OP_DEL = 2'b10,
        OP_MOD = 2'b11
    } upd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_SEEK,
        ST_FILL,
        ST_ARM,
        ST_DONE
    } upd_state_e;

endpackage

// File: rtl/upd_valid_bank.sv
module upd_valid_bank #(
    parameter int ROWS  = 4,
    parameter int SLOTS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_val,
    input  logic [RW-1:0] wr_row,
    input  logic [SW-1:0] wr_slot,
    input  logic [RW-1:0] rd_row,
    input  logic [SW-1:0] rd_slot,
    output logic          rd_busy,
    output logic          bottom_full
);

    logic [ROWS*SLOTS-1:0] flat;

    // one register row per array row
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [SLOTS-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (wr_en && (wr_row == RW'(r))) begin
                row_q[wr_slot] <= wr_val;
            end
        end
        assign flat[r*SLOTS +: SLOTS] = row_q;
    end

    assign rd_busy     = flat[int'(rd_row)*SLOTS + int'(rd_slot)];
    assign bottom_full = &flat[(ROWS-1)*SLOTS +: SLOTS];

    // a rule is only armed in a slot that was free
    AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val) |-> !flat[int'(wr_row)*SLOTS + int'(wr_slot)]); // R4

endmodule

// File: rtl/upd_fit_check.sv
module upd_fit_check #(
    parameter int ROWS   = 4,
    parameter int NSTG   = 4,
    parameter int STRIDE = 2,
    parameter logic [ROWS*NSTG-1:0] WILD_MAP = '0,
    localparam int RW = $clog2(ROWS),
    localparam int PW = NSTG*STRIDE
) (
    input  logic [RW-1:0] row,
    input  logic [PW-1:0] care,
    input  logic          slot_busy,
    output logic          fit,
    output logic          clash
);

    logic [NSTG-1:0] stage_care;
    logic [NSTG-1:0] row_wild;

    // a stage matters when any of its bits is fixed
    for (genvar g = 0; g < NSTG; g++) begin : g_stg
        assign stage_care[g] = |care[g*STRIDE +: STRIDE];
    end

    assign row_wild = WILD_MAP[int'(row)*NSTG +: NSTG];
    assign clash    = |(row_wild & stage_care);
    assign fit      = !slot_busy && !clash;

endmodule

// File: rtl/upd_fill_seq.sv
module upd_fill_seq #(
    parameter int ROWS   = 4,
    parameter int NSTG   = 4,
    parameter int STRIDE = 2,
    parameter logic [ROWS*NSTG-1:0] WILD_MAP = '0,
    localparam int RW   = $clog2(ROWS),
    localparam int GW   = $clog2(NSTG),
    localparam int PW   = NSTG*STRIDE,
    localparam int KEYS = 1 << STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RW-1:0]     row,
    input  logic [PW-1:0]     value,
    input  logic [PW-1:0]     care,
    output logic              tw_en,
    output logic [GW-1:0]     tw_stage,
    output logic [STRIDE-1:0] tw_key,
    output logic              tw_bit,
    output logic              last
);

    logic              active_q;
    logic [GW-1:0]     stg_q;
    logic [STRIDE-1:0] key_q;
    logic              step_wild;
    logic              stage_end;
    logic [STRIDE-1:0] sub_val;
    logic [STRIDE-1:0] sub_care;

    assign step_wild = WILD_MAP[int'(row)*NSTG + int'(stg_q)];
    assign stage_end = step_wild || (key_q == STRIDE'(KEYS-1));
    assign sub_val   = value[int'(stg_q)*STRIDE +: STRIDE];
    assign sub_care  = care[int'(stg_q)*STRIDE +: STRIDE];

    assign last     = active_q && stage_end && (stg_q == GW'(NSTG-1));
    assign tw_en    = active_q && !step_wild;
    assign tw_stage = stg_q;
    assign tw_key   = key_q;
    assign tw_bit   = ((key_q ^ sub_val) & sub_care) == '0;

    // walk stages and keys; a wildcard stage costs one idle step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            stg_q    <= '0;
            key_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            stg_q    <= '0;
            key_q    <= '0;
        end else if (active_q) begin
            if (last) begin
                active_q <= 1'b0;
            end else if (stage_end) begin
                stg_q <= stg_q + GW'(1);
                key_q <= '0;
            end else begin
                key_q <= key_q + STRIDE'(1);
            end
        end
    end

    AST_SEQ_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q); // R8

endmodule

// File: rtl/sink_rule_updater.sv
module sink_rule_updater
    import upd_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int SLOTS  = 8,
    parameter int NSTG   = 4,
    parameter int STRIDE = 2,
    parameter logic [ROWS*NSTG-1:0] WILD_MAP = 16'h028C,
    localparam int RW = $clog2(ROWS),
    localparam int SW = $clog2(SLOTS),
    localparam int GW = $clog2(NSTG),
    localparam int PW = NSTG*STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [RW+SW-1:0]  cmd_id,
    input  logic [PW-1:0]     cmd_value,
    input  logic [PW-1:0]     cmd_care,
    output logic              tw_en,
    output logic [RW-1:0]     tw_row,
    output logic [SW-1:0]     tw_slot,
    output logic [GW-1:0]     tw_stage,
    output logic [STRIDE-1:0] tw_key,
    output logic              tw_bit,
    output logic              vb_en,
    output logic [RW-1:0]     vb_row,
    output logic [SW-1:0]     vb_slot,
    output logic              vb_val,
    output logic              done,
    output logic              done_ovf,
    output logic [RW-1:0]     done_row,
    output logic [SW-1:0]     done_slot,
    output logic              bottom_full
);

    upd_state_e    state_q, state_d;
    upd_op_e       op_q;
    logic [RW-1:0] row_q, row_d;
    logic [SW-1:0] slot_q;
    logic [PW-1:0] val_q;
    logic [PW-1:0] care_q;
    logic          ovf_q, ovf_d;
    logic          take;
    logic          slot_busy;
    logic          fit;
    logic          clash;
    logic          seq_start;
    logic          seq_last;
    logic          bank_wr;
    logic          bank_val;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        ovf_d   = ovf_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    take  = 1'b1;
                    ovf_d = 1'b0;
                    row_d = cmd_id[SW +: RW];
                    unique case (upd_op_e'(cmd_op))
                        OP_NOP:         state_d = ST_DONE;
                        OP_INS:         state_d = ST_SEEK;
                        OP_DEL, OP_MOD: state_d = ST_DROP;
                        default:        state_d = ST_DONE;
                    endcase
                end
            end
            ST_DROP: begin
                state_d = (op_q == OP_DEL) ? ST_DONE : ST_SEEK;
            end
            ST_SEEK: begin
                if (fit) begin
                    state_d = ST_FILL;
                end else if (row_q == RW'(ROWS-1)) begin
                    state_d = ST_DONE;
                    ovf_d   = 1'b1;
                end else begin
                    row_d = row_q + RW'(1);
                end
            end
            ST_FILL: begin
                if (seq_last) begin
                    state_d = ST_ARM;
                end
            end
            ST_ARM:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NOP;
            row_q   <= '0;
            slot_q  <= '0;
            val_q   <= '0;
            care_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            ovf_q   <= ovf_d;
            if (take) begin
                op_q   <= upd_op_e'(cmd_op);
                slot_q <= cmd_id[SW-1:0];
                val_q  <= cmd_value;
                care_q <= cmd_care;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd_ready = 1'b0;
        bank_wr   = 1'b0;
        bank_val  = 1'b0;
        done      = 1'b0;
        seq_start = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_DROP: bank_wr   = 1'b1;
            ST_SEEK: seq_start = fit;
            ST_FILL: ;
            ST_ARM: begin
                bank_wr  = 1'b1;
                bank_val = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign vb_en     = bank_wr;
    assign vb_val    = bank_val;
    assign vb_row    = row_q;
    assign vb_slot   = slot_q;
    assign tw_row    = row_q;
    assign tw_slot   = slot_q;
    assign done_ovf  = ovf_q;
    assign done_row  = row_q;
    assign done_slot = slot_q;

    // ---------------- sub-blocks ----------------
    upd_valid_bank #(
        .ROWS  (ROWS),
        .SLOTS (SLOTS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bank_wr),
        .wr_val      (bank_val),
        .wr_row      (row_q),
        .wr_slot     (slot_q),
        .rd_row      (row_q),
        .rd_slot     (slot_q),
        .rd_busy     (slot_busy),
        .bottom_full (bottom_full)
    );

    upd_fit_check #(
        .ROWS     (ROWS),
        .NSTG     (NSTG),
        .STRIDE   (STRIDE),
        .WILD_MAP (WILD_MAP)
    ) u_fit (
        .row       (row_q),
        .care      (care_q),
        .slot_busy (slot_busy),
        .fit       (fit),
        .clash     (clash)
    );

    upd_fill_seq #(
        .ROWS     (ROWS),
        .NSTG     (NSTG),
        .STRIDE   (STRIDE),
        .WILD_MAP (WILD_MAP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .row      (row_q),
        .value    (val_q),
        .care     (care_q),
        .tw_en    (tw_en),
        .tw_stage (tw_stage),
        .tw_key   (tw_key),
        .tw_bit   (tw_bit),
        .last     (seq_last)
    );

    // ---------------- assertions ----------------
    AST_FILL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |-> (!slot_busy && !clash)); // R4
    AST_ARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_en && vb_val) |-> $past(seq_last)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tw_en, vb_en, done})); // R7
    AST_READY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tw_en); // R8
    AST_OVF_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ovf) |-> !$past(tw_en)); // R6

endmodule

// File: tb/sink_rule_updater_tb.sv
module sink_rule_updater_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS   = 4;
    localparam int SLOTS  = 8;
    localparam int NSTG   = 4;
    localparam int STRIDE = 2;
    localparam int KEYS   = 4;
    localparam int PW     = 8;
    localparam logic [15:0] WMAP = 16'h028C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic [4:0] cmd_id = '0;
    logic [7:0] cmd_value = '0;
    logic [7:0] cmd_care = '0;
    logic       tw_en, tw_bit, vb_en, vb_val, done, done_ovf, bottom_full;
    logic [1:0] tw_row, tw_stage, tw_key, vb_row, done_row;
    logic [2:0] tw_slot, vb_slot, done_slot;

    int  errs = 0;
    int  checks = 0;
    bit  mv [ROWS][SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sink_rule_updater dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_value(cmd_value), .cmd_care(cmd_care),
        .tw_en(tw_en), .tw_row(tw_row), .tw_slot(tw_slot), .tw_stage(tw_stage),
        .tw_key(tw_key), .tw_bit(tw_bit), .vb_en(vb_en), .vb_row(vb_row),
        .vb_slot(vb_slot), .vb_val(vb_val), .done(done), .done_ovf(done_ovf),
        .done_row(done_row), .done_slot(done_slot), .bottom_full(bottom_full)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit wild(input int r, input int g);
        return WMAP[r*NSTG + g];
    endfunction

    function automatic bit clash(input int r, input logic [7:0] care);
        for (int g = 0; g < NSTG; g++)
            if (wild(r, g) && (|care[g*STRIDE +: STRIDE])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit model_full();
        for (int s = 0; s < SLOTS; s++) if (!mv[ROWS-1][s]) return 1'b0;
        return 1'b1;
    endfunction

    // op: 1 insert, 2 delete, 3 modify
    task automatic run_op(input logic [1:0] op, input int home, input int slot,
                          input logic [7:0] val, input logic [7:0] care);
        int land = -1;
        int tested = 0;
        int exp_busy = 0;
        int exp_w = 0;
        int busy = 0, nw = 0, bad = 0, nset = 0, nclr = 0, set_w = -1;
        int clr_bad = 0, set_bad = 0;
        bit got_ovf = 0;
        int got_row = 0, got_slot = 0;
        // ---- expected from model ----
        if (op == 2'b10) begin
            mv[home][slot] = 1'b0;
            exp_busy = 2;
        end else begin
            if (op == 2'b11) mv[home][slot] = 1'b0;
            for (int r = home; r < ROWS; r++) begin
                tested++;
                if (!mv[r][slot] && !clash(r, care)) begin land = r; break; end
            end
            if (land >= 0) begin
                int nstd = 0;
                for (int g = 0; g < NSTG; g++) if (!wild(land, g)) nstd++;
                exp_w = nstd * KEYS;
                exp_busy = tested + exp_w + (NSTG - nstd) + 2;
                mv[land][slot] = 1'b1;
            end else begin
                exp_busy = tested + 1;
            end
            if (op == 2'b11) exp_busy++;
        end
        // ---- drive; command held through the busy period ----
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = 5'((home << 3) | slot);
        cmd_value = val; cmd_care = care;
        while (!cmd_ready) @(negedge clk);
        forever begin
            @(negedge clk);
            busy++;
            if (tw_en) begin
                logic [1:0] sv, sc;
                sv = val[int'(tw_stage)*STRIDE +: STRIDE];
                sc = care[int'(tw_stage)*STRIDE +: STRIDE];
                nw++;
                if (int'(tw_row) != land || int'(tw_slot) != slot ||
                    wild(int'(tw_row), int'(tw_stage)) ||
                    tw_bit != (((tw_key ^ sv) & sc) == 2'b00)) bad++;
            end
            if (vb_en) begin
                if (vb_val) begin
                    nset++; set_w = nw;
                    if (int'(vb_row) != land || int'(vb_slot) != slot) set_bad++;
                end else begin
                    nclr++;
                    if (int'(vb_row) != home || int'(vb_slot) != slot || nw != 0) clr_bad++;
                end
            end
            if (done) begin
                got_ovf = done_ovf; got_row = done_row; got_slot = done_slot;
                chk(bottom_full == model_full(), "R9 bottom_full", bottom_full, model_full());
                cmd_valid = 1'b0;
                break;
            end
            if (busy > 500) break;
        end
        // ---- checks ----
        chk(busy == exp_busy, "R8 busy cycles", busy, exp_busy);
        if (op == 2'b10) begin
            chk(nclr == 1 && clr_bad == 0, "R2 delete clear", nclr, 1);
            chk(nw == 0 && nset == 0, "R2 no writes on delete", nw + nset, 0);
            chk(!got_ovf && got_row == home && got_slot == slot, "R2 done place", got_row, home);
        end else begin
            if (op == 2'b11)
                chk(nclr == 1 && clr_bad == 0, "R5 modify clears first", nclr, 1);
            else
                chk(nclr == 0, "R3 insert issues no clear", nclr, 0);
            if (land >= 0) begin
                chk(!got_ovf, "R4 no overflow", got_ovf, 0);
                chk(got_row == land && got_slot == slot, "R4 landing row", got_row, land);
                chk(nw == exp_w, "R3 table write count", nw, exp_w);
                chk(bad == 0, "R3 table write content", bad, 0);
                chk(nset == 1 && set_bad == 0 && set_w == exp_w, "R7 valid set after fill", nset, 1);
            end else begin
                chk(got_ovf, "R6 overflow status", got_ovf, 1);
                chk(nw == 0 && nset == 0, "R6 no writes on overflow", nw + nset, 0);
            end
        end
        @(negedge clk);
        chk(cmd_ready && !done, "R8 ready again, no re-accept", cmd_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int r = 0; r < ROWS; r++) for (int s = 0; s < SLOTS; s++) mv[r][s] = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !done && !bottom_full && !tw_en && !vb_en, "R1 reset outputs", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !done && !bottom_full, "R1 after reset", cmd_ready, 1);

        run_op(2'b01, 0, 0, 8'h5A, 8'h0F);   // R3 home row
        run_op(2'b01, 0, 1, 8'h99, 8'hCC);   // R4 three rows down
        run_op(2'b01, 0, 0, 8'h01, 8'h03);   // R4 slot taken, next row
        run_op(2'b10, 0, 0, 8'h00, 8'h00);   // R2 delete in wildcard row
        run_op(2'b11, 1, 0, 8'h40, 8'hC0);   // R5 modify sinks to row 2
        run_op(2'b01, 0, 1, 8'h99, 8'hCC);   // R6 overflow insert
        run_op(2'b01, 3, 0, 8'h00, 8'h00);   // take bottom slot 0
        run_op(2'b11, 2, 0, 8'h04, 8'h0C);   // R6 modify overflow
        for (int s = 2; s < SLOTS; s++) run_op(2'b01, 3, s, 8'(s), 8'hFF); // R9 fill
        run_op(2'b10, 3, 4, 8'h00, 8'h00);   // R9 drop

        for (int i = 0; i < 80; i++) begin
            logic [1:0] op;
            logic [7:0] care;
            int pick = $urandom % 10;
            op = (pick < 5) ? 2'b01 : (pick < 7) ? 2'b10 : 2'b11;
            care = 8'h00;
            for (int g = 0; g < NSTG; g++)
                if ($urandom % 3 == 0) care[g*STRIDE +: STRIDE] = 2'($urandom);
            run_op(op, $urandom % ROWS, $urandom % SLOTS, 8'($urandom), care);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule